// File: doc/BRIEF.md
# Routable Interrupt Controller with Software-Raised Sources

This block collects interrupt requests from 32 sources and steers each one to one of five interrupt lines toward a processor. Every source owns a configuration word that holds an enable, a line select and a 23-bit target thread tag. Each source also has a pending flag. The lower sixteen sources latch their flags from hardware request inputs. The upper sixteen have no hardware input and serve as software-raised (inter-processor) interrupts.

Software reaches the block over a simple 64-bit register bus with a one-cycle read latency. The byte address splits into a 2-bit region field (address bits 9:8) and an offset. Region 0 holds the configuration words, one per source at offset index × 8, so address bits 7:3 pick the source. Region 1 returns the raw pending vector. A write to region 2 raises every pending flag written as 1. A write to region 3 drops every pending flag written as 1. An interrupt line is high whenever some enabled, pending source selects it.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every pending flag and every configuration word is zero, all five lines are low and no read response is signalled.
- R2: A configuration word reads back with the line select in bits 3:0, the thread tag in bits 30:8 and the enable in bit 31. Bits 7:4 and 63:32 always read as zero, whatever was written to them.
- R3: Writing a configuration word of zero leaves the source disabled and routed to line 0, so it drives no line even while it is pending.
- R4: A high hardware request input sets its pending flag at the next clock edge. The flag stays set after the input falls, until a clear write. A clear write loses against a request input that is high in the same cycle.
- R5: A write to the set region (region 2) sets each pending flag whose bit in data bits 31:0 is 1 and leaves the other flags unchanged. Sources 16 to 31 can be raised only this way.
- R6: A write to the clear region (region 3) clears each pending flag whose bit is 1 and leaves the other flags unchanged. If a set and a clear reach the same flag together, the set wins.
- R7: A read of the pending region (region 1) returns the pending vector in bits 31:0, with bit n for source n, whether or not each source is enabled. Bits 63:32 read as zero.
- R8: Line k (0 to 4) is high exactly when at least one source is pending, enabled and has line select equal to k. A select value from 5 to 15 drives no line.
- R9: The read response is valid in the cycle after the read request and reflects the state before any later write. Writes to the pending region are ignored. Reads of the set and clear regions return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_irq_i | input | 16 | Hardware request inputs for sources 0 to 15 |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 10 | Byte address: bits 9:8 region, bits 7:3 source index |
| bus_wdata_i | input | 64 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata_o | output | 64 | Read data |
| irq_o | output | 5 | Interrupt lines toward the processor |

## Verification
The hardest cases to reach are a clear write that lands while a hardware request input is still high, and a source that is pending but whose configuration has just been zeroed. From the ports the flag looks the same whether the clear was lost or was never sent. To separate the two, the stimulus holds a request input high across a clear write and reads the pending region back. It then drops the input and clears the flag again. For the zeroed source, the stimulus keeps the flag pending and rewrites the configuration to zero, then checks both the line and the readback.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  localparam int DATA_W  = 64;
  localparam int SEL_W   = 4;
  localparam int TID_W   = 23;
  localparam int SEL_LSB = 0;
  localparam int TID_LSB = 8;
  localparam int EN_BIT  = 31;
  localparam int RGN_W   = 2;

  typedef enum logic [RGN_W-1:0] {
    RGN_CFG  = 2'd0,
    RGN_PEND = 2'd1,
    RGN_SET  = 2'd2,
    RGN_CLR  = 2'd3
  } region_e;

  typedef struct packed {
    logic             en;
    logic [TID_W-1:0] tid;
    logic [SEL_W-1:0] sel;
  } src_cfg_t;

endpackage

// File: rtl/irqr_cfg_bank.sv
module irqr_cfg_bank
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output src_cfg_t [NUM_SRC-1:0]    cfg_o,
  output logic [DATA_W-1:0]         rd_word_o
);

  src_cfg_t [NUM_SRC-1:0] cfg_q;
  src_cfg_t [NUM_SRC-1:0] cfg_n;
  logic     [NUM_SRC-1:0] hit;
  src_cfg_t               wr_fields;
  src_cfg_t               rd_sel;
  logic                   unused_wdata;

  assign unused_wdata = ^{wr_data_i[DATA_W-1:EN_BIT+1], wr_data_i[TID_LSB-1:SEL_LSB+SEL_W]};

  always_comb begin
    wr_fields.en  = wr_data_i[EN_BIT];
    wr_fields.tid = wr_data_i[TID_LSB +: TID_W];
    wr_fields.sel = wr_data_i[SEL_LSB +: SEL_W];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_comb begin
      cfg_n[i] = cfg_q[i];
      if (hit[i]) cfg_n[i] = wr_fields;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[i] <= '0;
      else if (hit[i]) cfg_q[i] <= cfg_n[i];
    end

    AST_ZERO_CFG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && wr_data_i == '0) |=> (!cfg_q[i].en && cfg_q[i].sel == '0)); // R3
  end

  assign cfg_o  = cfg_q;
  assign rd_sel = cfg_q[rd_idx_i];

  always_comb begin
    rd_word_o                        = '0;
    rd_word_o[EN_BIT]                = rd_sel.en;
    rd_word_o[TID_LSB +: TID_W]      = rd_sel.tid;
    rd_word_o[SEL_LSB +: SEL_W]      = rd_sel.sel;
  end

  AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word_o[DATA_W-1:EN_BIT+1] == '0); // R2

endmodule

// File: rtl/irqr_pending.sv
module irqr_pending #(
  parameter int NUM_SRC   = 32,
  parameter int SOFT_BASE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SOFT_BASE-1:0] hw_i,
  input  logic [NUM_SRC-1:0]   set_i,
  input  logic [NUM_SRC-1:0]   clr_i,
  output logic [NUM_SRC-1:0]   pend_o
);

  logic [NUM_SRC-1:0] hw_ext;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_n;
  logic               pend_upd;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hw
    if (i < SOFT_BASE) begin : g_wired
      assign hw_ext[i] = hw_i[i];
    end else begin : g_soft
      assign hw_ext[i] = 1'b0;
    end
  end

  always_comb begin
    pend_n   = (pend_q & ~clr_i) | set_i | hw_ext;
    pend_upd = |{set_i, clr_i, hw_ext};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= '0;
    else if (pend_upd) pend_q <= pend_n;
  end

  assign pend_o = pend_q;

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_i & ~set_i & ~hw_ext)) == '0)); // R6
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(set_i)) == $past(set_i))); // R5
  AST_HW_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(hw_ext)) == $past(hw_ext))); // R4
  AST_NO_SPURIOUS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_i | hw_ext)) == '0)); // R4

endmodule

// File: rtl/irqr_route.sv
module irqr_route
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_OUT = 5
) (
  input  src_cfg_t [NUM_SRC-1:0] cfg_i,
  input  logic     [NUM_SRC-1:0] pend_i,
  output logic     [NUM_OUT-1:0] irq_o
);

  logic [NUM_SRC-1:0] live;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_live
    assign live[i] = pend_i[i] && cfg_i[i].en;
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_line
    logic [NUM_SRC-1:0] match;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign match[i] = live[i] && (cfg_i[i].sel == SEL_W'(j));
    end
    assign irq_o[j] = |match;
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irqr_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_OUT   = 5,
  parameter int SOFT_BASE = 16,
  parameter int ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SOFT_BASE-1:0] hw_irq_i,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [63:0]          bus_wdata_i,
  output logic                 bus_rvalid_o,
  output logic [63:0]          bus_rdata_o,
  output logic [NUM_OUT-1:0]   irq_o
);

  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int IDX_LSB = 3;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // decode
  region_e            region;
  logic [IDX_W-1:0]   idx;
  logic               wr_acc, rd_acc, cfg_wr;
  logic [NUM_SRC-1:0] set_mask, clr_mask;
  logic               unused_addr;

  assign region      = region_e'(bus_addr_i[ADDR_W-1 -: RGN_W]);
  assign idx         = bus_addr_i[IDX_LSB +: IDX_W];
  assign unused_addr = ^{bus_addr_i[ADDR_W-RGN_W-1:IDX_LSB+IDX_W], bus_addr_i[IDX_LSB-1:0]};

  always_comb begin
    wr_acc   = bus_req_i && bus_we_i;
    rd_acc   = bus_req_i && !bus_we_i;
    cfg_wr   = wr_acc && (region == RGN_CFG);
    set_mask = (wr_acc && region == RGN_SET) ? bus_wdata_i[NUM_SRC-1:0] : '0;
    clr_mask = (wr_acc && region == RGN_CLR) ? bus_wdata_i[NUM_SRC-1:0] : '0;
  end

  src_cfg_t [NUM_SRC-1:0] cfg;
  logic     [DATA_W-1:0]  cfg_word;
  logic     [NUM_SRC-1:0] pend;

  irqr_cfg_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (cfg_wr),
    .wr_idx_i  (idx),
    .wr_data_i (bus_wdata_i),
    .rd_idx_i  (idx),
    .cfg_o     (cfg),
    .rd_word_o (cfg_word)
  );

  irqr_pending #(.NUM_SRC(NUM_SRC), .SOFT_BASE(SOFT_BASE)) u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hw_i   (hw_irq_i),
    .set_i  (set_mask),
    .clr_i  (clr_mask),
    .pend_o (pend)
  );

  irqr_route #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_route (
    .cfg_i  (cfg),
    .pend_i (pend),
    .irq_o  (irq_o)
  );

  // read path: next-state then register
  logic [DATA_W-1:0] rdata_n, rdata_q;
  logic              rvalid_q;

  always_comb begin
    rdata_n = '0;
    unique case (region)
      RGN_CFG:  rdata_n = cfg_word;
      RGN_PEND: rdata_n = DATA_W'(pend);
      default:  rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= rdata_n;
    end
  end

  assign bus_rvalid_o = rvalid_q;
  assign bus_rdata_o  = rdata_q;

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (bus_rvalid_o == $past(bus_req_i && !bus_we_i))); // R9
  AST_PEND_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req_i && bus_we_i && region == RGN_PEND && hw_irq_i == '0)
      |=> (pend == $past(pend))); // R9
  AST_LINE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_o != '0) |-> (pend != '0)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (irq_o == '0 && !bus_rvalid_o)); // R1

endmodule

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] hw_irq;
  logic        req, we;
  logic [9:0]  addr;
  logic [63:0] wdata;
  logic        rvalid;
  logic [63:0] rdata;
  logic [4:0]  irq;

  always #2.5 clk = ~clk;

  irq_route_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_irq_i     (hw_irq),
    .bus_req_i    (req),
    .bus_we_i     (we),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rvalid_o (rvalid),
    .bus_rdata_o  (rdata),
    .irq_o        (irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model
  logic [63:0] m_cfg [32];
  logic [31:0] m_pend;
  logic [15:0] m_hw;

  logic [63:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [9:0] mk_addr(input logic [1:0] rgn, input int src);
    return {rgn, 5'(src), 3'b000};
  endfunction

  function automatic logic [4:0] exp_irq();
    logic [4:0] r = '0;
    for (int i = 0; i < 32; i++)
      if (m_pend[i] && m_cfg[i][31] && m_cfg[i][3:0] < 4'd5)
        r[m_cfg[i][2:0]] = 1'b1;
    return r;
  endfunction

  task automatic bus_write(input logic [1:0] rgn, input int src, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = mk_addr(rgn, src); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
    case (rgn)
      2'd0: m_cfg[src] = d & 64'h0000_0000_FFFF_FF0F;
      2'd2: m_pend = m_pend | d[31:0];
      2'd3: m_pend = m_pend & ~d[31:0];
      default: ;
    endcase
    m_pend = m_pend | {16'h0, m_hw};
  endtask

  task automatic bus_read(input logic [1:0] rgn, input int src, input string tag);
    logic [63:0] e;
    case (rgn)
      2'd0: e = m_cfg[src];
      2'd1: e = {32'h0, m_pend};
      default: e = '0;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = mk_addr(rgn, src);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic drive_hw(input logic [15:0] v);
    @(negedge clk);
    hw_irq = v; m_hw = v;
    @(negedge clk);
    m_pend = m_pend | {16'h0, m_hw};
  endtask

  task automatic check_irq(input string tag);
    logic [4:0] e = exp_irq();
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq_o actual=%b expected=%b", tag, irq, e);
    end
  endtask

  // monitor: pops expected read data as responses arrive
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected read response actual=%h expected=none", rdata);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_irq = '0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    m_pend = '0; m_hw = '0;
    for (int i = 0; i < 32; i++) m_cfg[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    checks++;
    if (rvalid !== 1'b0) begin
      failures++;
      $display("FAIL R1 rvalid actual=%b expected=0", rvalid);
    end
    check_irq("R1 lines low after reset");
    bus_read(2'd0, 0,  "R1 cfg0 zero");
    bus_read(2'd0, 31, "R1 cfg31 zero");
    bus_read(2'd1, 0,  "R1 pending zero");

    // R2 field layout and masking of unused bits
    bus_write(2'd0, 3, 64'hDEAD_BEEF_0000_0000 | (64'h1 << 31) | (64'h5A5A5A << 8) | 64'hF2);
    bus_read(2'd0, 3, "R2 cfg3 readback masked");
    bus_write(2'd0, 30, 64'h0000_0000_7FFF_FFFF);
    bus_read(2'd0, 30, "R2 cfg30 tid all ones, disabled");

    // R5/R8 software set routes to line 2
    bus_write(2'd2, 0, 64'h1 << 3);
    check_irq("R8 src3 drives line 2");
    bus_read(2'd1, 0, "R7 pending shows src3");

    // R5 soft source 20 on line 4
    bus_write(2'd0, 20, (64'h1 << 31) | 64'h4);
    bus_write(2'd2, 0, 64'h1 << 20);
    check_irq("R5 soft src20 drives line 4");

    // R8 select out of range drives nothing
    bus_write(2'd0, 7, (64'h1 << 31) | 64'h9);
    bus_write(2'd2, 0, 64'h1 << 7);
    check_irq("R8 select 9 drives no line");

    // R8 disabled source drives nothing
    bus_write(2'd0, 9, 64'h1);
    bus_write(2'd2, 0, 64'h1 << 9);
    check_irq("R8 disabled src9 silent");
    bus_read(2'd1, 0, "R7 pending raw includes disabled");

    // R6 clear
    bus_write(2'd3, 0, (64'h1 << 3) | (64'h1 << 20));
    check_irq("R6 clear drops lines 2 and 4");
    bus_read(2'd1, 0, "R6 pending after clear");

    // R4 hardware request latching
    bus_write(2'd0, 5, (64'h1 << 31) | 64'h0);
    drive_hw(16'h0020);
    check_irq("R4 hw src5 drives line 0");
    drive_hw(16'h0000);
    check_irq("R4 src5 stays pending after input falls");
    bus_read(2'd1, 0, "R4 pending held");

    // R4 clear loses to concurrent request
    bus_write(2'd0, 6, (64'h1 << 31) | 64'h1);
    drive_hw(16'h0040);
    bus_write(2'd3, 0, 64'h1 << 6);
    bus_read(2'd1, 0, "R4 clear lost to high input");
    check_irq("R4 line 1 still high");
    drive_hw(16'h0000);
    bus_write(2'd3, 0, 64'h1 << 6);
    check_irq("R4 line 1 low after real clear");

    // R3 zero configuration disables a pending source
    bus_write(2'd0, 5, 64'h0);
    check_irq("R3 zeroed src5 silent");
    bus_read(2'd0, 5, "R3 cfg5 zero");

    // R9 ignored write and write-only regions
    bus_write(2'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_read(2'd1, 0, "R9 pending write ignored");
    bus_read(2'd2, 0, "R9 set region reads zero");
    bus_read(2'd3, 0, "R9 clear region reads zero");
    check_irq("R9 lines unchanged after ignored write");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule